// File: doc/BRIEF.md
# Upscaled ROM Picture Display

This block sits between a 640x480 VGA timing generator and a bank of small stored pictures. Every clock it takes the generator's current column, row, visible flag and the two sync levels. From the coordinates it forms a read address into an external image ROM that holds several 160x120 pictures back to back. It then presents the returned 12-bit colour to the display together with sync pulses that have been delayed to match the read.

Each source pixel is repeated as a 4x4 block, so one stored picture covers the whole visible screen. A set of push buttons, one per picture, picks the picture to show. A press is held as a pending choice and only takes effect when the scan reaches the top-left corner of the screen. This keeps a frame from showing two pictures at once. Colour is forced to black wherever the screen is blanked.

Top module: `upscale_rom_display`

## Requirements
- R1: A synchronous active-low reset forces colour to zero, both sync outputs high (inactive) and the picture index to 0. After reset the ROM address during blanking is 0.
- R2: While the visible flag is high, the ROM address equals index*19200 + (row>>2)*160 + (column>>2).
- R3: While the visible flag is low, the ROM address is index*19200, the first word of the current picture.
- R4: The ROM is assumed to return the word for an address one clock later. The colour output shows that word on the second rising edge after the coordinates were presented.
- R5: The horizontal and vertical sync outputs equal the sync inputs delayed by exactly two clocks, so they stay aligned with the colour.
- R6: The colour output is zero whenever the visible flag two clocks earlier was low, whatever the ROM returns.
- R7: A high button bit i records picture i as the pending choice. If several bits are high at once, the lowest index wins. A press in the same cycle as the top-left corner is kept for the next frame.
- R8: A pending choice becomes the displayed picture starting with the coordinate (column 0, row 0). That coordinate already reads from the new picture.
- R9: If several presses arrive before the corner is reached, the most recent one is used.
- R10: A pending choice has no effect on the address at any coordinate other than the top-left corner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_col | input | 10 | Current column from the timing generator |
| pix_row | input | 10 | Current row from the timing generator |
| pix_visible | input | 1 | High inside the 640x480 visible area |
| hsync_in | input | 1 | Horizontal sync from the generator, active low |
| vsync_in | input | 1 | Vertical sync from the generator, active low |
| sel_btn | input | 4 | One button per stored picture, high when pressed |
| rom_addr | output | 17 | Read address to the image ROM |
| rom_data | input | 12 | ROM word, valid one clock after its address |
| rgb_out | output | 12 | Colour, red in bits 11:8, green 7:4, blue 3:0 |
| hsync_out | output | 1 | Delayed horizontal sync, active low |
| vsync_out | output | 1 | Delayed vertical sync, active low |

## Verification
The address path is driven with columns and rows on either side of every multiple of four, such as 3/4/5, 159/160 and 636/639, and with the last visible row. These show whether the 4x4 replication divides correctly and whether the row term is scaled by the source width. Blanked stretches are driven with moving sync pulses to separate a correct two-clock delay from a one-clock delay, and to show that blanking forces black instead of passing ROM data. Button sequences separate simultaneous presses, repeated presses, presses landing on the corner cycle, and pending choices that must wait for the top-left coordinate. A ROM model in the bench returns an address-dependent word, so a wrong address or a wrong latency shows up as a wrong colour.

// File: rtl/disp_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the upscaled picture display.
// Assumes active-low sync levels from the timing generator.
package disp_pkg;

    // Control bits that travel beside the colour through the pipeline.
    typedef struct packed {
        logic hsync;
        logic vsync;
        logic visible;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{hsync: 1'b1, vsync: 1'b1, visible: 1'b0};

endpackage

// File: rtl/image_select.sv
`timescale 1ns/1ps
// Module: image_select
// Holds the displayed picture index and a pending choice taken from the
// buttons. The pending choice is applied only at the top-left coordinate.
// The effective index is combinational so that this coordinate already
// reads from the new picture.
// Assumes debounced, level-type button inputs.
module image_select #(
    parameter int NUM_IMAGES = 4,
    parameter int COORD_W    = 10,
    localparam int IDX_W     = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IMAGES-1:0] sel_btn,
    input  logic [COORD_W-1:0]    pix_col,
    input  logic [COORD_W-1:0]    pix_row,
    output logic [IDX_W-1:0]      img_idx
);

    logic [IDX_W-1:0] img_q;
    logic [IDX_W-1:0] pend_q;
    logic             pend_valid_q;
    logic [IDX_W-1:0] btn_enc;
    logic             btn_any;
    logic             at_origin;

    // Purpose: pick the lowest pressed button index.
    always_comb begin
        btn_enc = '0;
        for (int i = NUM_IMAGES - 1; i >= 0; i--) begin
            if (sel_btn[i]) btn_enc = IDX_W'(i);
        end
    end

    assign btn_any   = |sel_btn;
    assign at_origin = (pix_col == '0) && (pix_row == '0);

    // Purpose: effective index, switching exactly at the frame origin.
    always_comb begin
        img_idx = img_q;
        if (at_origin && pend_valid_q) img_idx = pend_q;
    end

    // Purpose: keep the shown index and the newest pending choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q        <= '0;
            pend_q       <= '0;
            pend_valid_q <= 1'b0;
        end else begin
            img_q <= img_idx;
            if (btn_any) begin
                pend_q       <= btn_enc;
                pend_valid_q <= 1'b1;
            end else if (at_origin) begin
                pend_valid_q <= 1'b0;
            end
        end
    end

    // R8: the shown index only moves at the top-left coordinate.
    a_r8_switch_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(img_q) |-> $past(at_origin));

    // R7: any press leaves a pending choice behind.
    a_r7_press_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        btn_any |=> pend_valid_q);

endmodule

// File: rtl/addr_gen.sv
`timescale 1ns/1ps
// Module: addr_gen
// Forms the ROM read address from screen coordinates. Each source pixel
// covers a (1<<SCALE_SHIFT) square of screen pixels. Pictures are stored
// back to back, each SRC_W*SRC_H words. Outside the visible area, only
// the picture base is driven.
// Assumes visible coordinates stay below SRC_W<<SCALE_SHIFT and
// SRC_H<<SCALE_SHIFT.
module addr_gen #(
    parameter int NUM_IMAGES  = 4,
    parameter int SRC_W       = 160,
    parameter int SRC_H       = 120,
    parameter int SCALE_SHIFT = 2,
    parameter int COORD_W     = 10,
    localparam int IDX_W      = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1,
    localparam int IMG_PIXELS = SRC_W * SRC_H,
    localparam int ADDR_W     = $clog2(NUM_IMAGES * IMG_PIXELS)
) (
    input  logic [IDX_W-1:0]   img_idx,
    input  logic [COORD_W-1:0] pix_col,
    input  logic [COORD_W-1:0] pix_row,
    input  logic               pix_visible,
    output logic [ADDR_W-1:0]  rom_addr
);

    logic [COORD_W-1:0] src_col;
    logic [COORD_W-1:0] src_row;
    logic [ADDR_W-1:0]  img_base;
    logic [ADDR_W-1:0]  pix_offset;

    // Purpose: map screen coordinates to source coordinates.
    generate
        if (SCALE_SHIFT == 0) begin : g_no_scale
            assign src_col = pix_col;
            assign src_row = pix_row;
        end else begin : g_scale
            assign src_col = pix_col >> SCALE_SHIFT;
            assign src_row = pix_row >> SCALE_SHIFT;
        end
    endgenerate

    // Purpose: picture base plus the in-picture offset when visible.
    always_comb begin
        img_base   = ADDR_W'(img_idx) * ADDR_W'(IMG_PIXELS);
        pix_offset = ADDR_W'(src_row) * ADDR_W'(SRC_W) + ADDR_W'(src_col);
        rom_addr   = pix_visible ? (img_base + pix_offset) : img_base;
    end

endmodule

// File: rtl/pix_align.sv
`timescale 1ns/1ps
// Module: pix_align
// Two-stage pipeline. The first stage holds the sync and visible bits
// while the ROM read is in flight. The second stage registers the ROM
// word (blanked if not visible) together with the delayed syncs.
// Assumes the ROM returns data one clock after the address.
module pix_align
    import disp_pkg::*;
#(
    parameter int RGB_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             visible_in,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [RGB_W-1:0] rom_data,
    output logic [RGB_W-1:0] rgb_out,
    output logic             hsync_out,
    output logic             vsync_out
);

    ctrl_t ctl_d1;

    // Purpose: hold control bits for the ROM read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_d1 <= CTRL_IDLE;
        else        ctl_d1 <= '{hsync: hsync_in, vsync: vsync_in, visible: visible_in};
    end

    // Purpose: register colour and syncs together at the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_out   <= '0;
            hsync_out <= 1'b1;
            vsync_out <= 1'b1;
        end else begin
            rgb_out   <= ctl_d1.visible ? rom_data : '0;
            hsync_out <= ctl_d1.hsync;
            vsync_out <= ctl_d1.vsync;
        end
    end

    // R6: blanked slots come out black.
    a_r6_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_d1.visible |=> (rgb_out == '0));

endmodule

// File: rtl/upscale_rom_display.sv
`timescale 1ns/1ps
// Module: upscale_rom_display (top)
// Shows one of NUM_IMAGES stored low-resolution pictures, scaled up to
// fill the screen. Coordinates and syncs come from a VGA timing generator.
// The ROM is external and has one clock of read latency.
// Output latency is two clocks for colour and syncs alike.
module upscale_rom_display #(
    parameter int NUM_IMAGES  = 4,
    parameter int SRC_W       = 160,
    parameter int SRC_H       = 120,
    parameter int SCALE_SHIFT = 2,
    parameter int COORD_W     = 10,
    parameter int RGB_W       = 12,
    localparam int IDX_W      = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1,
    localparam int IMG_PIXELS = SRC_W * SRC_H,
    localparam int ADDR_W     = $clog2(NUM_IMAGES * IMG_PIXELS),
    localparam int SCREEN_W   = SRC_W << SCALE_SHIFT,
    localparam int SCREEN_H   = SRC_H << SCALE_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [COORD_W-1:0]    pix_col,
    input  logic [COORD_W-1:0]    pix_row,
    input  logic                  pix_visible,
    input  logic                  hsync_in,
    input  logic                  vsync_in,
    input  logic [NUM_IMAGES-1:0] sel_btn,
    output logic [ADDR_W-1:0]     rom_addr,
    input  logic [RGB_W-1:0]      rom_data,
    output logic [RGB_W-1:0]      rgb_out,
    output logic                  hsync_out,
    output logic                  vsync_out
);

    logic [IDX_W-1:0] img_idx;

    image_select #(
        .NUM_IMAGES (NUM_IMAGES),
        .COORD_W    (COORD_W)
    ) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_btn (sel_btn),
        .pix_col (pix_col),
        .pix_row (pix_row),
        .img_idx (img_idx)
    );

    addr_gen #(
        .NUM_IMAGES  (NUM_IMAGES),
        .SRC_W       (SRC_W),
        .SRC_H       (SRC_H),
        .SCALE_SHIFT (SCALE_SHIFT),
        .COORD_W     (COORD_W)
    ) u_addr (
        .img_idx     (img_idx),
        .pix_col     (pix_col),
        .pix_row     (pix_row),
        .pix_visible (pix_visible),
        .rom_addr    (rom_addr)
    );

    pix_align #(
        .RGB_W (RGB_W)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .visible_in (pix_visible),
        .hsync_in   (hsync_in),
        .vsync_in   (vsync_in),
        .rom_data   (rom_data),
        .rgb_out    (rgb_out),
        .hsync_out  (hsync_out),
        .vsync_out  (vsync_out)
    );

    // Purpose: count edges since reset so delay checks start cleanly.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    // R5: sync outputs trail the inputs by two clocks.
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2) |-> (hsync_out == $past(hsync_in, 2)) &&
                             (vsync_out == $past(vsync_in, 2)));

    // R2: visible coordinates inside the screen map inside the ROM.
    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_visible && (pix_col < COORD_W'(SCREEN_W)) && (pix_row < COORD_W'(SCREEN_H)))
            |-> (int'(rom_addr) < NUM_IMAGES * IMG_PIXELS));

    // R3: blanked coordinates point at a picture's first word.
    a_r3_blank_base: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_visible |-> ((int'(rom_addr) % IMG_PIXELS) == 0));

endmodule

// File: tb/upscale_rom_display_bench.sv
`timescale 1ns/1ps
module upscale_rom_display_bench;

    localparam int IMG_PIXELS = 19200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pix_col = '0;
    logic [9:0]  pix_row = '0;
    logic        pix_visible = 1'b0;
    logic        hsync_in = 1'b1;
    logic        vsync_in = 1'b1;
    logic [3:0]  sel_btn = '0;
    logic [16:0] rom_addr;
    logic [11:0] rom_data;
    logic [11:0] rgb_out;
    logic        hsync_out;
    logic        vsync_out;

    int n_checks = 0;
    int n_err    = 0;

    // Bench-side picture selection model and two-deep expectation pipe.
    int   m_img = 0, m_pend = 0;
    bit   m_pv  = 0;
    logic [11:0] p1_rgb = '0, p2_rgb = '0;
    logic p1_hs = 1, p2_hs = 1, p1_vs = 1, p2_vs = 1, p1_vis = 0, p2_vis = 0;

    always #2 clk = ~clk;

    upscale_rom_display u_upscale_rom_display (
        .clk, .rst_n, .pix_col, .pix_row, .pix_visible, .hsync_in, .vsync_in,
        .sel_btn, .rom_addr, .rom_data, .rgb_out, .hsync_out, .vsync_out
    );

    function automatic logic [11:0] rom_fn(input logic [16:0] a);
        logic [31:0] t;
        t = 32'(a) * 32'd37 + 32'(a >> 5);
        return t[11:0] ^ 12'hA5C;
    endfunction

    // ROM model with one clock of read latency.
    always_ff @(posedge clk) rom_data <= rom_fn(rom_addr);

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One pixel clock: check outputs due now, drive new inputs, check address.
    task automatic step(input bit rst, input int col, input int row, input bit vis,
                        input bit hs, input bit vs, input logic [3:0] b);
        int eff, exp_addr, enc;
        logic [11:0] n_rgb;
        @(negedge clk);
        check(p2_vis ? "R4 colour" : "R6 blank colour", rgb_out, p2_rgb);
        check("R5 hsync", hsync_out, p2_hs);
        check("R5 vsync", vsync_out, p2_vs);
        rst_n = ~rst; pix_col = 10'(col); pix_row = 10'(row);
        pix_visible = vis; hsync_in = hs; vsync_in = vs; sel_btn = b;
        #1;
        if (rst) begin
            m_img = 0; m_pend = 0; m_pv = 0;
            p2_rgb = p1_rgb; p2_hs = p1_hs; p2_vs = p1_vs; p2_vis = p1_vis;
            p1_rgb = '0; p1_hs = 1; p1_vs = 1; p1_vis = 0;
        end else begin
            eff = (col == 0 && row == 0 && m_pv) ? m_pend : m_img;
            exp_addr = eff * IMG_PIXELS + (vis ? (row / 4) * 160 + col / 4 : 0);
            check(vis ? "R2 address" : "R3 blank address", rom_addr, exp_addr);
            m_img = eff;
            enc = -1;
            for (int i = 3; i >= 0; i--) if (b[i]) enc = i;
            if (enc >= 0) begin m_pend = enc; m_pv = 1; end
            else if (col == 0 && row == 0) m_pv = 0;
            n_rgb = vis ? rom_fn(17'(exp_addr)) : 12'h000;
            p2_rgb = p1_rgb; p2_hs = p1_hs; p2_vs = p1_vs; p2_vis = p1_vis;
            p1_rgb = n_rgb; p1_hs = hs; p1_vs = vs; p1_vis = vis;
        end
    endtask

    task automatic check_img(input string tag, input int exp);
        check(tag, int'(rom_addr) / IMG_PIXELS, exp);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) step(1, 9, 9, 1, 0, 0, 4'b0100);
        check("R1 reset colour", rgb_out, 0);
        check("R1 reset hsync", hsync_out, 1);
        check("R1 reset vsync", vsync_out, 1);
        step(0, 700, 490, 0, 1, 1, 4'b0000);
        check("R1 reset address", rom_addr, 0);
        step(0, 0, 0, 0, 1, 1, 4'b0000);
        check_img("R1 reset picture", 0);
    endtask

    task automatic t_scan();
        int rows[6] = '{0, 3, 4, 7, 240, 479};
        int cols[10] = '{0, 1, 3, 4, 5, 159, 160, 636, 637, 639};
        foreach (rows[r]) begin
            foreach (cols[c]) step(0, cols[c], rows[r], 1, 1, 1, 4'b0000);
        end
        for (int c = 0; c < 48; c++) step(0, c, 121, 1, 1, 1, 4'b0000);
    endtask

    task automatic t_blank();
        for (int c = 640; c < 800; c += 5)
            step(0, c, 100, 0, (c >= 656 && c < 752) ? 1'b0 : 1'b1, 1'b1, 4'b0000);
        for (int r = 480; r < 525; r++)
            step(0, r % 7, r, 0, r[0], (r == 490 || r == 491) ? 1'b0 : 1'b1, 4'b0000);
        step(0, 5, 5, 1, 1, 1, 4'b0000);
        step(0, 6, 5, 0, 0, 1, 4'b0000);
        step(0, 7, 5, 1, 1, 0, 4'b0000);
    endtask

    task automatic t_select();
        step(0, 10, 10, 1, 1, 1, 4'b0100);
        step(0, 11, 10, 1, 1, 1, 4'b0000);
        check_img("R10 pending not shown mid-frame", 0);
        step(0, 0, 1, 1, 1, 1, 4'b0000);
        check_img("R10 column 0 of later row", 0);
        step(0, 0, 0, 1, 1, 1, 4'b0000);
        check_img("R8 switch at origin", 2);
        step(0, 300, 200, 1, 1, 1, 4'b0000);
        check_img("R8 new picture held", 2);
    endtask

    task automatic t_priority();
        step(0, 20, 30, 1, 1, 1, 4'b1010);
        step(0, 0, 0, 1, 1, 1, 4'b0000);
        check_img("R7 lowest index wins", 1);
    endtask

    task automatic t_latest();
        step(0, 50, 60, 1, 1, 1, 4'b1000);
        step(0, 51, 60, 1, 1, 1, 4'b0001);
        step(0, 0, 0, 0, 1, 1, 4'b0000);
        check_img("R9 latest press used", 0);
        step(0, 0, 0, 1, 1, 1, 4'b1000);
        check_img("R7 press on origin waits", 0);
        step(0, 1, 0, 1, 1, 1, 4'b0000);
        step(0, 0, 0, 1, 1, 1, 4'b0000);
        check_img("R7 press on origin applied next frame", 3);
        step(0, 639, 479, 1, 1, 1, 4'b0000);
        step(0, 640, 479, 0, 1, 1, 4'b0000);
        step(0, 641, 479, 0, 0, 0, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_scan();
        t_blank();
        t_select();
        t_priority();
        t_latest();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule